// File: doc/BRIEF.md
# Multicart PRG Page Mapper

This block turns a CPU program-space window number into a physical 8 KiB PRG page number for a multicart cartridge controller. The CPU region $8000 to $FFFF is split into four 8 KiB windows, numbered 0 to 3 from $8000 upward. The block never writes a register. It reads the current contents of the outer configuration registers, four inner bank registers and the invert flag of the bank-select control byte, and from these it computes the page for each of the four windows. The page for the requested window is driven out in the same cycle.

A 12-bit outer base is built from bit fields spread over three outer registers. A 3-bit size mode then picks one of three layouts. Mode 4 and above map one 32 KiB page over the whole region. Mode 3 maps one 16 KiB page twice. Modes 0 to 2 give a banked layout, with two switchable windows and two fixed windows. In this layout, a larger mode number shrinks the inner bank mask and gives more page bits to the outer base. When the extended flag is set, the banked layout uses four independent inner registers and applies no mask.

The block is purely combinational and carries no stream of data, so it has no valid/ready handshake. Every pin is a plain level. The page output follows the inputs within the same cycle. The surrounding controller holds the registers and uses the page to address its PRG memory.

Top module: `prg_page_mapper`

## Requirements
- R1: The outer base is {grp_hi[0], grp_hi[2:1], base_b8, base_b7, base_lo[6:0]}. Here grp_hi carries outer register 2 bits 7..5, base_b8 carries outer register 0 bit 7, base_b7 carries outer register 0 bit 3, and base_lo carries outer register 1 bits 6..0. The doubled base is the outer base shifted left by one, which gives a 13-bit value.
- R2: The page output is the page computed for the window selected by win_sel, where 0 selects $8000, 1 selects $A000, 2 selects $C000 and 3 selects $E000.
- R3: When size_mode is 4, 5, 6 or 7, page = (outer base >> 1) * 4 + win_sel.
- R4: When size_mode is 3, page = outer base * 2 + win_sel[0].
- R5: When size_mode is 0, 1 or 2 and ext_mode is 0, the inner mask is 0x3F >> size_mode. Page bits outside the mask come from the doubled base, and page bits inside the mask come from the window's inner value.
- R6: In R5's layout, the inner value is bank_r6 for $8000, bank_r7 for $A000, 0xFE for $C000 and 0xFF for $E000. This makes $E000 always the last page of the masked group.
- R7: When inv_prg is 1, in modes 0 to 2, the windows at $8000 and $C000 exchange their inner values. The $A000 and $E000 windows are not affected.
- R8: When size_mode is 0, 1 or 2 and ext_mode is 1, page = inner value OR doubled base, with no mask. The inner values are bank_r6, bank_r7, bank_r8 and bank_r9 for windows 0 to 3, and R7's exchange still applies.
- R9: inv_prg and ext_mode have no effect on the page in modes 3 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| size_mode | input | 3 | Size mode, outer register 0 bits 2..0 |
| base_b7 | input | 1 | Outer register 0 bit 3, base bit 7 |
| base_b8 | input | 1 | Outer register 0 bit 7, base bit 8 |
| base_lo | input | 7 | Outer register 1 bits 6..0, base bits 6..0 |
| grp_hi | input | 3 | Outer register 2 bits 7..5 |
| ext_mode | input | 1 | Outer register 3 bit 1, four-register layout |
| inv_prg | input | 1 | Bank-select control bit 6, swap $8000/$C000 |
| bank_r6 | input | 8 | Inner bank register 6 |
| bank_r7 | input | 8 | Inner bank register 7 |
| bank_r8 | input | 8 | Inner bank register 8 (extended only) |
| bank_r9 | input | 8 | Inner bank register 9 (extended only) |
| win_sel | input | 2 | CPU window number, 0 = $8000 .. 3 = $E000 |
| page | output | 13 | Physical 8 KiB PRG page |

## Verification
On every input change, the assertions check the low page bits in the 32 KiB and 16 KiB layouts. They also check that, in the masked banked layout, the bits above the mask come from the outer base and that $E000 reads the last page of its group. In the extended layout they check the OR with the doubled base for the $A000 window. A property on a single window cannot show the $8000/$C000 exchange, the full assembly of the scattered base bits, or that the invert and extended flags are ignored in the large layouts. Those are covered by the bench's sweeps, which step through every mode, flag pair and window with many register values, plus the all-zero and all-ones corners.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int WIN_CNT  = 4;
  localparam int WIN_W    = 2;
  localparam int MODE_W   = 3;

  typedef enum logic [1:0] {
    LAYOUT_BANKED = 2'd0,
    LAYOUT_HALF   = 2'd1,
    LAYOUT_WIDE   = 2'd2
  } layout_e;

  function automatic layout_e layout_of(input logic [MODE_W-1:0] m);
    if (m >= 3'd4)      return LAYOUT_WIDE;
    else if (m == 3'd3) return LAYOUT_HALF;
    else                return LAYOUT_BANKED;
  endfunction
endpackage

// File: rtl/prg_outer_base.sv
module prg_outer_base #(
  parameter int LO_W   = 7,
  parameter int BASE_W = 12
) (
  input  logic [LO_W-1:0]   base_lo,
  input  logic              base_b7,
  input  logic              base_b8,
  input  logic [2:0]        grp_hi,
  output logic [BASE_W-1:0] base,
  output logic [BASE_W:0]   base_x2
);
  localparam int FIXED_W = LO_W + 5;

  logic [FIXED_W-1:0] packed_base;

  always_comb begin
    packed_base = {grp_hi[0], grp_hi[2:1], base_b8, base_b7, base_lo};
    base        = BASE_W'(packed_base);
    base_x2     = {base, 1'b0};
  end
endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
  import prg_map_pkg::*;
#(
  parameter int WIN     = 0,
  parameter int INNER_W = 8,
  parameter int BASE_W  = 12
) (
  input  logic [MODE_W-1:0]  size_mode,
  input  logic               ext_mode,
  input  logic               inv_prg,
  input  logic [BASE_W-1:0]  base,
  input  logic [BASE_W:0]    base_x2,
  input  logic [INNER_W-1:0] bank_r6,
  input  logic [INNER_W-1:0] bank_r7,
  input  logic [INNER_W-1:0] bank_r8,
  input  logic [INNER_W-1:0] bank_r9,
  output logic [BASE_W:0]    page
);
  localparam int PAGE_W = BASE_W + 1;
  localparam int PAD_W  = PAGE_W - INNER_W;
  localparam logic [INNER_W-1:0] FIX_LOW  = INNER_W'(8'hFE);
  localparam logic [INNER_W-1:0] FIX_HIGH = INNER_W'(8'hFF);
  localparam logic [INNER_W-1:0] MASK_TOP = INNER_W'(8'h3F);
  localparam logic [WIN_W-1:0]   WIN_IDX  = WIN_W'(WIN);

  logic [INNER_W-1:0] inner_val;
  logic [INNER_W-1:0] inner_mask;
  logic [PAGE_W-1:0]  mask_wide;
  layout_e            layout;

  always_comb begin
    layout = layout_of(size_mode);
    inner_mask = MASK_TOP >> size_mode[1:0];
    mask_wide  = {{PAD_W{1'b0}}, inner_mask};
    inner_val  = '0;
    unique case (WIN_IDX)
      2'd0: inner_val = ext_mode ? (inv_prg ? bank_r8 : bank_r6)
                                 : (inv_prg ? FIX_LOW : bank_r6);
      2'd1: inner_val = bank_r7;
      2'd2: inner_val = ext_mode ? (inv_prg ? bank_r6 : bank_r8)
                                 : (inv_prg ? bank_r6 : FIX_LOW);
      2'd3: inner_val = ext_mode ? bank_r9 : FIX_HIGH;
      default: inner_val = '0;
    endcase
  end

  always_comb begin
    unique case (layout)
      LAYOUT_WIDE: page = {base[BASE_W-1:1], WIN_IDX};
      LAYOUT_HALF: page = {base, WIN_IDX[0]};
      default: begin
        if (ext_mode)
          page = {{PAD_W{1'b0}}, inner_val} | base_x2;
        else
          page = ({{PAD_W{1'b0}}, inner_val} & mask_wide) | (base_x2 & ~mask_wide);
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({size_mode, ext_mode, base_x2}) && WIN == 3
        && layout == LAYOUT_BANKED && !ext_mode)
      AST_LAST_PAGE_FIXED: assert ((page & mask_wide) == mask_wide); // R6
  end
endmodule

// File: rtl/prg_page_mapper.sv
module prg_page_mapper
  import prg_map_pkg::*;
#(
  parameter int INNER_W = 8,
  parameter int LO_W    = 7,
  parameter int BASE_W  = 12
) (
  input  logic [2:0]         size_mode,
  input  logic               base_b7,
  input  logic               base_b8,
  input  logic [LO_W-1:0]    base_lo,
  input  logic [2:0]         grp_hi,
  input  logic               ext_mode,
  input  logic               inv_prg,
  input  logic [INNER_W-1:0] bank_r6,
  input  logic [INNER_W-1:0] bank_r7,
  input  logic [INNER_W-1:0] bank_r8,
  input  logic [INNER_W-1:0] bank_r9,
  input  logic [1:0]         win_sel,
  output logic [BASE_W:0]    page
);
  localparam int PAGE_W = BASE_W + 1;
  localparam int MASK_W = 6;

  logic [BASE_W-1:0] base;
  logic [BASE_W:0]   base_x2;
  logic [PAGE_W-1:0] win_page [WIN_CNT];

  prg_outer_base #(.LO_W(LO_W), .BASE_W(BASE_W)) u_base (
    .base_lo (base_lo),
    .base_b7 (base_b7),
    .base_b8 (base_b8),
    .grp_hi  (grp_hi),
    .base    (base),
    .base_x2 (base_x2)
  );

  for (genvar w = 0; w < WIN_CNT; w++) begin : g_win
    prg_window_map #(.WIN(w), .INNER_W(INNER_W), .BASE_W(BASE_W)) u_win (
      .size_mode (size_mode),
      .ext_mode  (ext_mode),
      .inv_prg   (inv_prg),
      .base      (base),
      .base_x2   (base_x2),
      .bank_r6   (bank_r6),
      .bank_r7   (bank_r7),
      .bank_r8   (bank_r8),
      .bank_r9   (bank_r9),
      .page      (win_page[w])
    );
  end

  assign page = win_page[win_sel];

  always_comb begin
    if (!$isunknown({size_mode, win_sel, base_x2, ext_mode, bank_r7, page})) begin
      if (size_mode >= 3'd4)
        AST_WIDE_LOW_BITS: assert (page[1:0] == win_sel); // R3
      if (size_mode == 3'd3)
        AST_HALF_LOW_BIT: assert (page[0] == win_sel[0]); // R4
      if (size_mode < 3'd3 && !ext_mode)
        AST_UPPER_FROM_BASE: assert (page[PAGE_W-1:MASK_W] == base_x2[PAGE_W-1:MASK_W]); // R5
      if (size_mode < 3'd3 && ext_mode && win_sel == 2'd1)
        AST_EXT_OR_BASE: assert (page == ({{(PAGE_W-INNER_W){1'b0}}, bank_r7} | base_x2)); // R8
    end
  end
endmodule

// File: tb/prg_page_mapper_tb.sv
module prg_page_mapper_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [2:0]  size_mode = '0;
  logic        base_b7 = 1'b0, base_b8 = 1'b0;
  logic [6:0]  base_lo = '0;
  logic [2:0]  grp_hi = '0;
  logic        ext_mode = 1'b0, inv_prg = 1'b0;
  logic [7:0]  bank_r6 = '0, bank_r7 = '0, bank_r8 = '0, bank_r9 = '0;
  logic [1:0]  win_sel = '0;
  logic [12:0] page;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  prg_page_mapper u_dut (
    .size_mode(size_mode), .base_b7(base_b7), .base_b8(base_b8),
    .base_lo(base_lo), .grp_hi(grp_hi), .ext_mode(ext_mode),
    .inv_prg(inv_prg), .bank_r6(bank_r6), .bank_r7(bank_r7),
    .bank_r8(bank_r8), .bank_r9(bank_r9), .win_sel(win_sel), .page(page)
  );

  function automatic int model();
    int b, m, v, pg;
    b = base_lo + 128 * base_b7 + 256 * base_b8
        + 512 * ((grp_hi >> 1) & 3) + 2048 * (grp_hi & 1);
    if (size_mode >= 4) return (b / 2) * 4 + win_sel;
    if (size_mode == 3) return b * 2 + (win_sel % 2);
    case (win_sel)
      2'd0: v = ext_mode ? (inv_prg ? bank_r8 : bank_r6) : (inv_prg ? 254 : bank_r6);
      2'd1: v = bank_r7;
      2'd2: v = ext_mode ? (inv_prg ? bank_r6 : bank_r8) : (inv_prg ? bank_r6 : 254);
      default: v = ext_mode ? bank_r9 : 255;
    endcase
    if (ext_mode) return (v | (b * 2)) % 8192;
    m  = 63 >> size_mode;
    pg = (v & m) | ((b * 2) & (8191 - m));
    return pg;
  endfunction

  function automatic string req_of();
    if (size_mode >= 4) return "R3";
    if (size_mode == 3) return "R4";
    if (ext_mode) return "R8";
    if (inv_prg && win_sel[0] == 1'b0) return "R7";
    if (win_sel != 2'd1) return "R6";
    return "R5";
  endfunction

  task automatic check(input string req);
    int exp;
    @(negedge clk);
    exp = model();
    n_cmp++;
    if (int'(page) != exp) begin
      n_bad++;
      $display("FAIL %s mode=%0d ext=%0d inv=%0d win=%0d actual=%0h expected=%0h",
               req, size_mode, ext_mode, inv_prg, win_sel, page, exp);
    end
    @(posedge clk);
  endtask

  task automatic randomize_regs();
    base_lo = 7'($urandom); base_b7 = 1'($urandom); base_b8 = 1'($urandom);
    grp_hi = 3'($urandom);
    bank_r6 = 8'($urandom); bank_r7 = 8'($urandom);
    bank_r8 = 8'($urandom); bank_r9 = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd77));
    // All-zero inputs: $8000 window, mode 0 (R2, R6)
    check("R6");
    win_sel = 2'd3; check("R6"); // last page of masked group = 0x3F
    // Base bit assembly, one field at a time, in mode 4 (R1)
    size_mode = 3'd4;
    for (int f = 0; f < 11; f++) begin
      base_lo = '0; base_b7 = 0; base_b8 = 0; grp_hi = '0;
      if (f < 7) base_lo = 7'(1 << f);
      else if (f == 7) base_b7 = 1;
      else if (f == 8) base_b8 = 1;
      else grp_hi = 3'(1 << (f - 8));
      win_sel = 2'(f);
      check("R1");
    end
    // Mode 3 base assembly including base bit 0 (R1, R4)
    size_mode = 3'd3; base_lo = 7'h55; grp_hi = 3'b101; check("R1");
    // All-ones corners in every layout (R2)
    base_lo = '1; base_b7 = 1; base_b8 = 1; grp_hi = '1;
    bank_r6 = '1; bank_r7 = '1; bank_r8 = '1; bank_r9 = '1;
    for (int md = 0; md < 8; md++)
      for (int w = 0; w < 4; w++) begin
        size_mode = 3'(md); win_sel = 2'(w); ext_mode = 1; check("R2");
      end
    ext_mode = 0;
    // Full sweep: modes, ext, invert, windows, random registers (R2..R9)
    for (int k = 0; k < 24; k++) begin
      randomize_regs();
      for (int md = 0; md < 8; md++)
        for (int e = 0; e < 2; e++)
          for (int iv = 0; iv < 2; iv++)
            for (int w = 0; w < 4; w++) begin
              size_mode = 3'(md); ext_mode = e[0]; inv_prg = iv[0]; win_sel = 2'(w);
              check(req_of());
            end
    end
    // Flags ignored in large layouts: compare against flag-clear page (R9)
    for (int k = 0; k < 16; k++) begin
      int ref_pg;
      randomize_regs();
      size_mode = 3'(3 + (k % 5)); win_sel = 2'(k);
      ext_mode = 0; inv_prg = 0;
      @(negedge clk); ref_pg = int'(page); @(posedge clk);
      ext_mode = 1; inv_prg = 1;
      @(negedge clk);
      n_cmp++;
      if (int'(page) != ref_pg) begin
        n_bad++;
        $display("FAIL R9 mode=%0d actual=%0h expected=%0h", size_mode, page, ref_pg);
      end
      @(posedge clk);
    end
    done = 1'b1;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (done || cycles >= 150000) begin
      if (!done) begin
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule